// File: doc/BRIEF.md
# Shadowed Configuration Register Bank

This block is the byte-addressed register file that sits behind the serial control port of a data converter. The port logic hands it a one-cycle write or read strobe together with an 8-bit address and 8-bit data. Writable settings land first in a master copy. They reach the live copy, which drives the rest of the chip, only when software issues a transfer command. A whole group of settings can therefore be staged one byte at a time and then applied in a single clock.

The bank holds a port-configuration byte, a chip identifier, a speed-grade code, a power-mode field, a global clock byte, a clock-divide byte and a test-mode byte. The port-configuration byte is mirrored, so it decodes the same whichever bit order the shifter used. It carries a bit-order select and a soft-reset request. The soft reset returns every register to its default value. Reads are registered, and the live settings are always present on dedicated output pins.

Top module: `cfg_shadow_regbank`

## Requirements
- R1: After reset, reads return 0x18 at 0x00, 0x00 at 0x08, 0x01 at 0x09, and 0x00 at 0x0B and 0x0D. The live outputs show power mode 00, duty-cycle stabilizer enabled, divide ratio 0, phase 0 and all test fields 0.
- R2: Address 0x01 always reads the parameter CHIP_ID (default 0x86), and writes to it change nothing.
- R3: Address 0x02 reads the parameter SPEED_GRADE in bits 5:4 (default 01, so the read gives 0x10), with all other bits 0. Writes to it change nothing.
- R4: A write to a shadowed register changes only its master copy, keeping only the defined bits: mask 0x03 at 0x08, 0x01 at 0x09, 0x3F at 0x0B and 0xBF at 0x0D. A read returns the master copy, and the live outputs stay unchanged until a transfer.
- R5: Writing 0xFF with bit 0 set raises a transfer flag. On the next clock every live copy takes its master value and the flag clears. While the flag is pending, a read of 0xFF returns 0x01; otherwise it returns 0x00. A write to 0xFF with bit 0 clear does nothing.
- R6: At 0x00, bit 6 or bit 1 selects LSB-first order (`lsb_first`). The read value is {0, L, S, 1, 1, S, L, 0}, where L is the bit-order select and S is a pending soft reset. Bits 7 and 0 are ignored.
- R7: Writing 0x00 with bit 5 or bit 2 set raises a soft-reset request. On the next clock the request returns every master, live copy, transfer flag and bit-order select to its default, and the request clears. A read issued in that same clock returns the pending request bits (0x3C when bit order is MSB-first).
- R8: Live field mapping: `live_pwr_mode` = 0x08[1:0] (00 normal, 01 full power-down, 10 standby, 11 reserved), `live_div_ratio` = 0x0B[2:0], `live_div_phase` = 0x0B[5:3], `live_test_sel` = 0x0D[3:0], `live_test_single` = 0x0D[7], and `live_pn_rst` = 0x0D[5:4]. `live_dcs_en` is 0x09[0] OR (divide ratio not zero).
- R9: Addresses other than 0x00, 0x01, 0x02, 0x08, 0x09, 0x0B, 0x0D and 0xFF read as 0x00, and writes to them change no register.
- R10: `rdata` is registered. It takes the addressed value on the clock where `rd_en` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| lsb_first | output | 1 | Serial bit order select |
| live_pwr_mode | output | 2 | Live power mode |
| live_dcs_en | output | 1 | Duty-cycle stabilizer active |
| live_div_ratio | output | 3 | Live clock divide ratio code |
| live_div_phase | output | 3 | Live divider phase adjust |
| live_test_sel | output | 4 | Live output test pattern select |
| live_test_single | output | 1 | Single-shot user pattern |
| live_pn_rst | output | 2 | PN generator resets {long, short} |

## Verification
The hardest states to reach are the single cycles in which the transfer flag or the soft-reset request is pending. Each lasts one clock and can be seen only by issuing a read in the very next cycle. The bench therefore drives each read strobe back-to-back with the triggering write, so that the read captures the pending value, and then checks the live outputs in the same cycle. A near-exhaustive sweep first reads all 256 addresses and then writes a known pattern to every address except 0x00 and 0xFF and reads it back. This shows that the masks, the read-only registers and the unmapped holes all behave as specified, and that no live output moves until a transfer.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 8;
    localparam int NUM_SHADOW = 4;

    localparam logic [ADDR_W-1:0] ADR_PORT  = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_ID    = 8'h01;
    localparam logic [ADDR_W-1:0] ADR_GRADE = 8'h02;
    localparam logic [ADDR_W-1:0] ADR_XFER  = 8'hFF;

    typedef logic [DATA_W-1:0] byte_t;
    typedef byte_t [NUM_SHADOW-1:0] bank_t;

    typedef enum logic [1:0] {
        PWR_NORMAL  = 2'b00,
        PWR_OFF     = 2'b01,
        PWR_STANDBY = 2'b10,
        PWR_RSVD    = 2'b11
    } pwr_mode_e;

    typedef struct packed {
        pwr_mode_e  pwr;
        logic       dcs_en;
        logic [2:0] div_ratio;
        logic [2:0] div_phase;
        logic [3:0] test_sel;
        logic       test_single;
        logic [1:0] pn_rst;
    } live_cfg_t;

    // Slot order of the shadowed bank: power, global clock, divide, test.
    function automatic logic [ADDR_W-1:0] shadow_addr(input int i);
        case (i)
            0:       return 8'h08;
            1:       return 8'h09;
            2:       return 8'h0B;
            default: return 8'h0D;
        endcase
    endfunction

    function automatic byte_t shadow_mask(input int i);
        case (i)
            0:       return 8'h03;
            1:       return 8'h01;
            2:       return 8'h3F;
            default: return 8'hBF;
        endcase
    endfunction

    function automatic byte_t shadow_default(input int i);
        case (i)
            1:       return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bank_t default_bank();
        bank_t b;
        for (int i = 0; i < NUM_SHADOW; i++) b[i] = shadow_default(i);
        return b;
    endfunction

    function automatic byte_t port_byte(input logic lsb, input logic srst);
        return {1'b0, lsb, srst, 2'b11, srst, lsb, 1'b0};
    endfunction

    function automatic live_cfg_t decode_live(input bank_t s);
        live_cfg_t r;
        r.pwr         = pwr_mode_e'(s[0][1:0]);
        r.div_ratio   = s[2][2:0];
        r.div_phase   = s[2][5:3];
        r.dcs_en      = s[1][0] | (s[2][2:0] != 3'd0);
        r.test_sel    = s[3][3:0];
        r.test_single = s[3][7];
        r.pn_rst      = s[3][5:4];
        return r;
    endfunction

endpackage

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic port_wr,
    input  logic lsb_req,
    input  logic srst_req,
    output logic lsb_first,
    output logic srst_q
);

    always_ff @(posedge clk) begin
        if (rst || srst_q) begin
            lsb_first <= 1'b0;
            srst_q    <= 1'b0;
        end else if (port_wr) begin
            lsb_first <= lsb_req;
            srst_q    <= srst_req;
        end
    end

    // R7: a soft-reset request lives exactly one cycle and clears bit order
    assert_srst_selfclear_R7: assert property (@(posedge clk) disable iff (rst)
        srst_q |=> (!srst_q && !lsb_first));

endmodule

// File: rtl/cfg_master_bank.sv
module cfg_master_bank
    import cfg_regbank_pkg::*;
(
    input  logic                clk,
    input  logic                clear,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  byte_t               wdata,
    output bank_t               master_q
);

    logic [NUM_SHADOW-1:0] hit;

    for (genvar g = 0; g < NUM_SHADOW; g++) begin : g_decode
        assign hit[g] = wr_en && (addr == shadow_addr(g));
    end

    always_ff @(posedge clk) begin
        if (clear) begin
            master_q <= default_bank();
        end else begin
            for (int i = 0; i < NUM_SHADOW; i++)
                if (hit[i]) master_q[i] <= wdata & shadow_mask(i);
        end
    end

    // R9: a write that matches no shadowed address leaves every master intact
    assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (clear)
        (wr_en && (hit == '0)) |=> $stable(master_q));

    // R4: undefined bits of a master never become set
    assert_master_mask_R4: assert property (@(posedge clk) disable iff (clear)
        ((master_q[0] & ~8'h03) == 8'h00) && ((master_q[1] & ~8'h01) == 8'h00) &&
        ((master_q[2] & ~8'h3F) == 8'h00) && ((master_q[3] & ~8'hBF) == 8'h00));

endmodule

// File: rtl/cfg_slave_bank.sv
module cfg_slave_bank
    import cfg_regbank_pkg::*;
(
    input  logic   clk,
    input  logic   clear,
    input  logic   xfer_set,
    input  bank_t  master_q,
    output bank_t  slave_q,
    output logic   xfer_q
);

    always_ff @(posedge clk) begin
        if (clear) begin
            slave_q <= default_bank();
            xfer_q  <= 1'b0;
        end else begin
            if (xfer_q) slave_q <= master_q;
            xfer_q <= xfer_set;
        end
    end

    // R4: live copies move only on a pending transfer
    assert_slave_hold_R4: assert property (@(posedge clk) disable iff (clear)
        !xfer_q |=> $stable(slave_q));

    // R5: a pending transfer copies the whole master bank in one step
    assert_xfer_copy_R5: assert property (@(posedge clk) disable iff (clear)
        xfer_q |=> (slave_q == $past(master_q)));

    // R5: the transfer flag clears itself unless re-armed
    assert_xfer_clear_R5: assert property (@(posedge clk) disable iff (clear)
        (xfer_q && !xfer_set) |=> !xfer_q);

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import cfg_regbank_pkg::*;
#(
    parameter byte_t      CHIP_ID     = 8'h86,
    parameter logic [1:0] SPEED_GRADE = 2'b01
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  bank_t               master_q,
    input  byte_t               port_val,
    input  logic                xfer_q,
    output byte_t               rdata
);

    byte_t rd_next;

    always_comb begin
        rd_next = '0;
        case (addr)
            ADR_PORT:  rd_next = port_val;
            ADR_ID:    rd_next = CHIP_ID;
            ADR_GRADE: rd_next = {2'b00, SPEED_GRADE, 4'b0000};
            ADR_XFER:  rd_next = {7'd0, xfer_q};
            default: begin
                for (int i = 0; i < NUM_SHADOW; i++)
                    if (addr == shadow_addr(i)) rd_next = master_q[i];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end

    // R10: read data holds without a read strobe
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    // R2: the identity register always returns the fixed code
    assert_chip_id_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADR_ID) |=> (rdata == CHIP_ID));

endmodule

// File: rtl/cfg_shadow_regbank.sv
module cfg_shadow_regbank
    import cfg_regbank_pkg::*;
#(
    parameter logic [7:0] CHIP_ID     = 8'h86,
    parameter logic [1:0] SPEED_GRADE = 2'b01
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        lsb_first,
    output logic [1:0]  live_pwr_mode,
    output logic        live_dcs_en,
    output logic [2:0]  live_div_ratio,
    output logic [2:0]  live_div_phase,
    output logic [3:0]  live_test_sel,
    output logic        live_test_single,
    output logic [1:0]  live_pn_rst
);

    logic      srst_q;
    logic      clear;
    logic      xfer_q;
    logic      xfer_set;
    logic      port_wr;
    bank_t     master_q;
    bank_t     slave_q;
    live_cfg_t live;

    assign port_wr  = wr_en && (addr == ADR_PORT);
    assign xfer_set = wr_en && (addr == ADR_XFER) && wdata[0];
    assign clear    = rst || srst_q;

    cfg_port_ctrl u_port (
        .clk       (clk),
        .rst       (rst),
        .port_wr   (port_wr),
        .lsb_req   (wdata[6] | wdata[1]),
        .srst_req  (wdata[5] | wdata[2]),
        .lsb_first (lsb_first),
        .srst_q    (srst_q)
    );

    cfg_master_bank u_master (
        .clk      (clk),
        .clear    (clear),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .master_q (master_q)
    );

    cfg_slave_bank u_slave (
        .clk      (clk),
        .clear    (clear),
        .xfer_set (xfer_set),
        .master_q (master_q),
        .slave_q  (slave_q),
        .xfer_q   (xfer_q)
    );

    cfg_read_mux #(
        .CHIP_ID     (CHIP_ID),
        .SPEED_GRADE (SPEED_GRADE)
    ) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .addr     (addr),
        .master_q (master_q),
        .port_val (port_byte(lsb_first, srst_q)),
        .xfer_q   (xfer_q),
        .rdata    (rdata)
    );

    assign live             = decode_live(slave_q);
    assign live_pwr_mode    = live.pwr;
    assign live_dcs_en      = live.dcs_en;
    assign live_div_ratio   = live.div_ratio;
    assign live_div_phase   = live.div_phase;
    assign live_test_sel    = live.test_sel;
    assign live_test_single = live.test_single;
    assign live_pn_rst      = live.pn_rst;

    // R1: a hard reset leaves the live settings at their defaults
    assert_reset_live_R1: assert property (@(posedge clk)
        $past(rst) |-> (live_pwr_mode == 2'b00 && live_dcs_en && !lsb_first));

endmodule

// File: tb/cfg_shadow_regbank_tb.sv
module cfg_shadow_regbank_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata;
    logic       lsb_first, live_dcs_en, live_test_single;
    logic [1:0] live_pwr_mode, live_pn_rst;
    logic [2:0] live_div_ratio, live_div_phase;
    logic [3:0] live_test_sel;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [7:0] mdl [256];
    logic [7:0] sl08, sl09, sl0b, sl0d;
    logic       m_lsb;

    always #10 clk = ~clk;

    cfg_shadow_regbank dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .lsb_first(lsb_first),
        .live_pwr_mode(live_pwr_mode), .live_dcs_en(live_dcs_en),
        .live_div_ratio(live_div_ratio), .live_div_phase(live_div_phase),
        .live_test_sel(live_test_sel), .live_test_single(live_test_single),
        .live_pn_rst(live_pn_rst)
    );

    function automatic logic [7:0] mask_of(input logic [7:0] a);
        case (a)
            8'h08: return 8'h03;
            8'h09: return 8'h01;
            8'h0B: return 8'h3F;
            8'h0D: return 8'hBF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return {1'b0, m_lsb, 1'b0, 2'b11, 1'b0, m_lsb, 1'b0};
            8'h01: return 8'h86;
            8'h02: return 8'h10;
            8'h08, 8'h09, 8'h0B, 8'h0D: return mdl[a];
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_defaults();
        for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
        mdl[8'h09] = 8'h01;
        sl08 = 8'h00; sl09 = 8'h01; sl0b = 8'h00; sl0d = 8'h00;
        m_lsb = 1'b0;
    endtask

    task automatic model_xfer();
        sl08 = mdl[8'h08]; sl09 = mdl[8'h09]; sl0b = mdl[8'h0B]; sl0d = mdl[8'h0D];
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Starts and ends at a falling edge; one rising edge captures the write.
    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (mask_of(a) != 8'h00) mdl[a] = d & mask_of(a);
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] q);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        q = rdata;
    endtask

    task automatic check_live(input string tag);
        logic [2:0] ratio;
        ratio = sl0b[2:0];
        chk({tag, " R8 pwr"},    live_pwr_mode, sl08[1:0]);
        chk({tag, " R8 ratio"},  live_div_ratio, ratio);
        chk({tag, " R8 phase"},  live_div_phase, sl0b[5:3]);
        chk({tag, " R8 dcs"},    live_dcs_en, sl09[0] | (ratio != 3'd0));
        chk({tag, " R8 tsel"},   live_test_sel, sl0d[3:0]);
        chk({tag, " R8 single"}, live_test_single, sl0d[7]);
        chk({tag, " R8 pn"},     live_pn_rst, sl0d[5:4]);
        chk({tag, " R6 lsb"},    lsb_first, m_lsb);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] q, held;
        model_defaults();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, then full read sweep (R2, R3, R9 included)
        check_live("R1 reset");
        for (int a = 0; a < 256; a++) begin
            do_read(a[7:0], q);
            chk($sformatf("R1/R9 read a=%0h", a), q, exp_read(a[7:0]));
        end

        // R4, R9, R2, R3: write sweep over all but 0x00 and 0xFF
        for (int a = 1; a < 255; a++) begin
            do_write(a[7:0], a[7:0] ^ 8'h5A);
            do_read(a[7:0], q);
            chk($sformatf("R4/R9 wr-rd a=%0h", a), q, exp_read(a[7:0]));
        end
        chk("R2 id after writes", exp_read(8'h01), 8'h86);
        check_live("R4 no transfer yet");

        // R5: transfer, flag visible for exactly the pending cycle
        do_write(8'hFF, 8'h01);
        do_read(8'hFF, q);
        chk("R5 flag pending", q, 8'h01);
        model_xfer();
        check_live("R5 after transfer");
        do_read(8'hFF, q);
        chk("R5 flag cleared", q, 8'h00);

        // R5: bit 0 clear does not transfer
        do_write(8'h08, 8'h01);
        do_write(8'hFF, 8'hFE);
        @(negedge clk);
        check_live("R5 no-op transfer");
        do_read(8'hFF, q);
        chk("R5 no flag", q, 8'h00);
        do_write(8'hFF, 8'h01);
        @(negedge clk);
        model_xfer();
        check_live("R5 pwr full power-down");

        // R8: forced stabilizer by nonzero divide
        do_write(8'h09, 8'h00);
        do_write(8'h0B, 8'h28);
        do_write(8'hFF, 8'h01);
        @(negedge clk);
        model_xfer();
        check_live("R8 ratio 0 dcs off");
        chk("R8 dcs off", live_dcs_en, 1'b0);
        do_write(8'h0B, 8'h05);
        do_write(8'h0D, 8'hFF);
        do_write(8'h08, 8'h02);
        do_write(8'hFF, 8'h01);
        @(negedge clk);
        model_xfer();
        check_live("R8 ratio 5 forced");
        chk("R8 dcs forced", live_dcs_en, 1'b1);

        // R6: mirrored port configuration
        do_write(8'h00, 8'h40); m_lsb = 1'b1;
        do_read(8'h00, q);
        chk("R6 bit6 read", q, 8'h5A);
        chk("R6 bit6 lsb", lsb_first, 1'b1);
        do_write(8'h00, 8'h00); m_lsb = 1'b0;
        do_read(8'h00, q);
        chk("R6 clear read", q, 8'h18);
        do_write(8'h00, 8'h02); m_lsb = 1'b1;
        do_read(8'h00, q);
        chk("R6 bit1 read", q, 8'h5A);
        do_write(8'h00, 8'h81); m_lsb = 1'b0;
        do_read(8'h00, q);
        chk("R6 ignored bits", q, 8'h18);
        chk("R6 ignored lsb", lsb_first, 1'b0);

        // R10: rdata holds without a strobe
        do_read(8'h01, held);
        addr = 8'h08;
        repeat (3) @(negedge clk);
        chk("R10 hold", rdata, held);

        // R7: soft reset via bit 5, read in the pending cycle
        do_write(8'h00, 8'h20);
        do_read(8'h00, q);
        chk("R7 pending bits", q, 8'h3C);
        model_defaults();
        check_live("R7 bit5 reset");
        for (int a = 0; a < 16; a++) begin
            do_read(a[7:0], q);
            chk($sformatf("R7 defaults a=%0h", a), q, exp_read(a[7:0]));
        end

        // R7: soft reset via bit 2 with bit-order set too
        do_write(8'h0D, 8'h83);
        do_write(8'hFF, 8'h01);
        @(negedge clk);
        model_xfer();
        do_write(8'h00, 8'h42); m_lsb = 1'b1;
        check_live("R7 before");
        do_write(8'h00, 8'h66);
        @(negedge clk);
        model_defaults();
        check_live("R7 bit2 reset");
        do_read(8'h0D, q);
        chk("R7 master cleared", q, 8'h00);
        do_read(8'hFF, q);
        chk("R7 flag cleared", q, 8'h00);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule